// File: doc/BRIEF.md
# Page Table Mapping Range Enumerator

This block walks a whole radix page table held in memory and reports which parts of the virtual address space are mapped, and with which access rights. It visits every entry depth-first, starting from a root table pointer. It computes the effective protection of each leaf page and of each unmapped span. Adjacent spans that end up with the same protection are folded together into one record. Each record holds a start address, an end address (exclusive) and a 3-bit protection value. Records are emitted in ascending address order, and only mapped spans produce records.

A mode input selects the depth of the walk. The deep mode has five levels and covers 12 + 5·IDX_W virtual address bits, which is 57 bits for 512-entry tables. The shallow mode has four levels and covers 12 + 4·IDX_W bits, which is 48 bits. Table entries are read one at a time through a valid/ready request port with a 64-bit response. A one-cycle done pulse marks the end of the walk. The block is used by a debug or management agent that needs a compact map of an address space without walking it in software.

Top module: `ptw_range_enum`

## Requirements
- R1: While reset is held, and afterwards until a start pulse, `mem_req_valid_o`, `rec_valid_o` and `done_o` are low.
- R2: At each level, entry i of a table is read at table base + i·8. Indices are visited in ascending order, depth-first. At most one read is outstanding, and a request holds its address until it is accepted.
- R3: The next-level table base is entry bits 51:12 with the low 12 bits zero. Entry bits 63:52 and 11:8 never affect the walk.
- R4: `five_lvl_i` and `root_i` are sampled on the start pulse and ignored afterwards until done. In deep mode the top index is VA bits 12+4·IDX_W upward. In shallow mode the walk begins at the fourth level, and the index above it is zero.
- R5: An entry with bit 7 set at level 2 or at level 1 is a leaf covering its whole span (level 0 is the last level). Bit 7 is ignored at levels 0, 3 and 4.
- R6: Protection is {user = bit 2, write = bit 1, present = bit 0}. A leaf's effective protection is its own three bits ANDed with those bits of every entry above it on the path.
- R7: An entry with bit 0 clear, at any level, gives protection 0 over its whole span, and the walk does not descend below it.
- R8: A record is emitted only when the protection changes, and only if the protection that ends there is nonzero. Its end is the address of the change and its start is the address of the previous change. Records ascend and do not overlap.
- R9: After the last entry, a boundary with protection 0 is applied at 2^(12+5·IDX_W) in deep mode or 2^(12+4·IDX_W) in shallow mode. `done_o` then pulses for one cycle, in the same cycle as the last record, and no record follows it.
- R10: A start pulse during a walk is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk (one-cycle pulse) |
| five_lvl_i | input | 1 | 1 selects five levels, 0 selects four |
| root_i | input | PA_W | Physical address of the top table |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | PA_W | Byte address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Entry read from memory |
| rec_valid_o | output | 1 | Range record valid (one cycle) |
| rec_start_o | output | 13+5·IDX_W | First address of the range |
| rec_end_o | output | 13+5·IDX_W | Address just past the range |
| rec_prot_o | output | 3 | {user, write, present} of the range |
| done_o | output | 1 | Walk complete (one cycle) |

## Verification
The bench builds the block with IDX_W = 2 (four entries per table) and PA_W = 24. At that size a complete five-level walk reaches at most 1024 leaves and finishes in a few thousand cycles, so every run enumerates the full address space rather than a sample of it. Tables are shared between parent entries, and their contents are generated from a seed. Across seeds and both modes, this covers non-present entries at every level, large-page leaves at levels 1 and 2, ignored size bits at the other levels, protection narrowing along the path, and merges that cross table boundaries. A uniform table checks that the whole space collapses into one record ending exactly at the top boundary. An empty root checks that no record is produced at all.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_WAIT,
    S_ADV,
    S_FLUSH,
    S_DONE
  } walk_state_e;

  localparam int PG_SHIFT = 12;
  localparam int N_LVL    = 5;
  localparam int BIT_P    = 0;
  localparam int BIT_W    = 1;
  localparam int BIT_U    = 2;
  localparam int BIT_PS   = 7;
endpackage

// File: rtl/ptw_rst_sync.sv
module ptw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/ptw_va_compose.sv
// Builds the virtual address of the entry under the cursor from the index
// stack: only levels between the cursor and the top contribute.
module ptw_va_compose #(
  parameter int IDX_W = 9,
  parameter int N_LVL = 5,
  parameter int AW    = 12 + IDX_W * N_LVL + 1
) (
  input  logic [N_LVL-1:0][IDX_W-1:0] idx_i,
  input  logic [2:0]                  lvl_i,
  input  logic [2:0]                  top_i,
  output logic [AW-1:0]               va_o
);
  logic [N_LVL-1:0][AW-1:0] term;

  for (genvar g = 0; g < N_LVL; g++) begin : g_term
    assign term[g] = (3'(g) >= lvl_i && 3'(g) <= top_i)
                   ? (AW'(idx_i[g]) << (12 + IDX_W * g)) : '0;
  end

  always_comb begin
    va_o = '0;
    for (int l = 0; l < N_LVL; l++) va_o = va_o | term[l];
  end
endmodule

// File: rtl/ptw_run_merge.sv
// Folds a stream of (boundary address, protection) events into range records.
module ptw_run_merge #(
  parameter int AW = 58
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          clr_i,
  input  logic          ev_valid_i,
  input  logic [AW-1:0] ev_addr_i,
  input  logic [2:0]    ev_prot_i,
  output logic          rec_valid_o,
  output logic [AW-1:0] rec_start_o,
  output logic [AW-1:0] rec_end_o,
  output logic [2:0]    rec_prot_o
);
  logic [2:0]    cur_q, cur_d;
  logic [AW-1:0] run_q, run_d;
  logic          chg, emit, run_en, out_en;

  always_comb begin
    chg    = ev_valid_i && (ev_prot_i != cur_q);
    emit   = chg && (cur_q != 3'b000);
    run_en = clr_i || chg;
    cur_d  = clr_i ? 3'b000 : ev_prot_i;
    run_d  = clr_i ? '0 : ev_addr_i;
    out_en = emit;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cur_q       <= 3'b000;
      run_q       <= '0;
      rec_valid_o <= 1'b0;
      rec_start_o <= '0;
      rec_end_o   <= '0;
      rec_prot_o  <= 3'b000;
    end else begin
      rec_valid_o <= emit && !clr_i;
      if (run_en) begin
        cur_q <= cur_d;
        run_q <= run_d;
      end
      if (out_en) begin
        rec_start_o <= run_q;
        rec_end_o   <= ev_addr_i;
        rec_prot_o  <= cur_q;
      end
    end
  end
endmodule

// File: rtl/ptw_range_enum.sv
module ptw_range_enum #(
  parameter int IDX_W = 9,
  parameter int PA_W  = 52
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       five_lvl_i,
  input  logic [PA_W-1:0]            root_i,
  output logic                       mem_req_valid_o,
  input  logic                       mem_req_ready_i,
  output logic [PA_W-1:0]            mem_req_addr_o,
  input  logic                       mem_rsp_valid_i,
  input  logic [63:0]                mem_rsp_data_i,
  output logic                       rec_valid_o,
  output logic [12+IDX_W*5:0]        rec_start_o,
  output logic [12+IDX_W*5:0]        rec_end_o,
  output logic [2:0]                 rec_prot_o,
  output logic                       done_o
);
  import ptw_pkg::*;

  localparam int VA_W = PG_SHIFT + IDX_W * N_LVL;
  localparam int AW   = VA_W + 1;

  logic rst_sn;
  ptw_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  walk_state_e                st_q, st_d;
  logic [2:0]                 lvl_q, lvl_d;
  logic                       five_q, five_d;
  logic [N_LVL-1:0][IDX_W-1:0] idx_q, idx_d;
  logic [N_LVL-1:0][PA_W-1:0]  base_q, base_d;
  logic [N_LVL-1:0][2:0]       acc_q, acc_d;

  logic [2:0]    top_lvl, e_prot;
  logic          e_pres, e_leaf, at_max, dat_en, clr;
  logic [51:0]   e_full;
  logic [PA_W-1:0] e_base, root_base;
  logic [AW-1:0] va_cur, va_end;
  logic          ev_valid;
  logic [AW-1:0] ev_addr;
  logic [2:0]    ev_prot;
  logic          unused_bits;

  assign unused_bits = ^{mem_rsp_data_i[63:52], mem_rsp_data_i[11:8],
                         mem_rsp_data_i[6:3], root_i[PG_SHIFT-1:0]};

  assign top_lvl   = five_q ? 3'd4 : 3'd3;
  assign e_pres    = mem_rsp_data_i[BIT_P];
  assign e_prot    = {mem_rsp_data_i[BIT_U], mem_rsp_data_i[BIT_W], mem_rsp_data_i[BIT_P]};
  assign e_full    = {mem_rsp_data_i[51:12], 12'h000};
  assign e_base    = e_full[PA_W-1:0];
  assign root_base = {root_i[PA_W-1:PG_SHIFT], 12'h000};
  assign e_leaf    = (lvl_q == 3'd0) ||
                     (((lvl_q == 3'd1) || (lvl_q == 3'd2)) && mem_rsp_data_i[BIT_PS]);
  assign at_max    = &idx_q[lvl_q];
  assign va_end    = AW'(1) << (five_q ? VA_W : VA_W - IDX_W);
  assign mem_req_addr_o = base_q[lvl_q] + PA_W'({idx_q[lvl_q], 3'b000});

  ptw_va_compose #(.IDX_W(IDX_W), .N_LVL(N_LVL), .AW(AW)) u_va (
    .idx_i (idx_q),
    .lvl_i (lvl_q),
    .top_i (top_lvl),
    .va_o  (va_cur)
  );

  always_comb begin
    st_d            = st_q;
    lvl_d           = lvl_q;
    five_d          = five_q;
    idx_d           = idx_q;
    base_d          = base_q;
    acc_d           = acc_q;
    mem_req_valid_o = 1'b0;
    ev_valid        = 1'b0;
    ev_addr         = va_cur;
    ev_prot         = 3'b000;
    clr             = 1'b0;
    done_o          = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start_i) begin
          clr    = 1'b1;
          five_d = five_lvl_i;
          lvl_d  = five_lvl_i ? 3'd4 : 3'd3;
          idx_d  = '0;
          base_d[five_lvl_i ? 3'd4 : 3'd3] = root_base;
          acc_d[five_lvl_i ? 3'd4 : 3'd3]  = 3'b111;
          st_d   = S_REQ;
        end
      end
      S_REQ: begin
        mem_req_valid_o = 1'b1;
        if (mem_req_ready_i) st_d = S_WAIT;
      end
      S_WAIT: begin
        if (mem_rsp_valid_i) begin
          if (!e_pres) begin
            ev_valid = 1'b1;
            st_d     = S_ADV;
          end else if (e_leaf) begin
            ev_valid = 1'b1;
            ev_prot  = acc_q[lvl_q] & e_prot;
            st_d     = S_ADV;
          end else begin
            lvl_d                 = lvl_q - 3'd1;
            base_d[lvl_q - 3'd1]  = e_base;
            idx_d[lvl_q - 3'd1]   = '0;
            acc_d[lvl_q - 3'd1]   = acc_q[lvl_q] & e_prot;
            st_d                  = S_REQ;
          end
        end
      end
      S_ADV: begin
        if (!at_max) begin
          idx_d[lvl_q] = idx_q[lvl_q] + 1'b1;
          st_d         = S_REQ;
        end else if (lvl_q == top_lvl) begin
          st_d = S_FLUSH;
        end else begin
          lvl_d = lvl_q + 3'd1;
        end
      end
      S_FLUSH: begin
        ev_valid = 1'b1;
        ev_addr  = va_end;
        st_d     = S_DONE;
      end
      S_DONE: begin
        done_o = 1'b1;
        st_d   = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  assign dat_en = (st_q != S_IDLE) || start_i;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= S_IDLE;
      lvl_q  <= 3'd0;
      five_q <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
      acc_q  <= '0;
    end else begin
      st_q <= st_d;
      if (dat_en) begin
        lvl_q  <= lvl_d;
        five_q <= five_d;
        idx_q  <= idx_d;
        base_q <= base_d;
        acc_q  <= acc_d;
      end
    end
  end

  ptw_run_merge #(.AW(AW)) u_merge (
    .clk         (clk),
    .rst_sn      (rst_sn),
    .clr_i       (clr),
    .ev_valid_i  (ev_valid),
    .ev_addr_i   (ev_addr),
    .ev_prot_i   (ev_prot),
    .rec_valid_o (rec_valid_o),
    .rec_start_o (rec_start_o),
    .rec_end_o   (rec_end_o),
    .rec_prot_o  (rec_prot_o)
  );
endmodule

// File: rtl/ptw_range_enum_chk.sv
module ptw_range_enum_chk #(
  parameter int IDX_W = 9,
  parameter int PA_W  = 52
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                mem_req_valid_o,
  input logic                mem_req_ready_i,
  input logic [PA_W-1:0]     mem_req_addr_o,
  input logic                mem_rsp_valid_i,
  input logic                rec_valid_o,
  input logic [12+IDX_W*5:0] rec_start_o,
  input logic [12+IDX_W*5:0] rec_end_o,
  input logic [2:0]          rec_prot_o,
  input logic                done_o
);
  localparam int AW = 13 + IDX_W * 5;

  logic          outst_q, busy_q, seen_q;
  logic [AW-1:0] last_end_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q    <= 1'b0;
      busy_q     <= 1'b0;
      seen_q     <= 1'b0;
      last_end_q <= '0;
    end else begin
      if (mem_req_valid_o && mem_req_ready_i) outst_q <= 1'b1;
      else if (mem_rsp_valid_i)               outst_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        seen_q <= 1'b0;
      end else if (done_o) begin
        busy_q <= 1'b0;
      end
      if (rec_valid_o) begin
        seen_q     <= 1'b1;
        last_end_q <= rec_end_o;
      end
    end
  end

  p_req_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> (mem_req_addr_o[2:0] == 3'b000));
  p_one_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> !outst_q);
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));
  p_rec_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o |-> (rec_prot_o != 3'b000));
  p_rec_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o |-> (rec_end_o > rec_start_o));
  p_rec_ascend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid_o && seen_q) |-> (rec_start_o >= last_end_q));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_rec_in_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o |-> busy_q);
endmodule

bind ptw_range_enum ptw_range_enum_chk #(.IDX_W(IDX_W), .PA_W(PA_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .start_i         (start_i),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_rsp_valid_i (mem_rsp_valid_i),
  .rec_valid_o     (rec_valid_o),
  .rec_start_o     (rec_start_o),
  .rec_end_o       (rec_end_o),
  .rec_prot_o      (rec_prot_o),
  .done_o          (done_o)
);

// File: tb/ptw_range_enum_tb.sv
`timescale 1ns/100ps
module ptw_range_enum_tb;
  localparam int IDX_W = 2;
  localparam int PA_W  = 24;
  localparam int AW    = 13 + IDX_W * 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n, start_i, five_lvl_i;
  logic [PA_W-1:0] root_i;
  logic            mem_req_valid_o, mem_req_ready_i, mem_rsp_valid_i;
  logic [PA_W-1:0] mem_req_addr_o;
  logic [63:0]     mem_rsp_data_i;
  logic            rec_valid_o, done_o;
  logic [AW-1:0]   rec_start_o, rec_end_o;
  logic [2:0]      rec_prot_o;

  ptw_range_enum #(.IDX_W(IDX_W), .PA_W(PA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .five_lvl_i(five_lvl_i),
    .root_i(root_i), .mem_req_valid_o(mem_req_valid_o),
    .mem_req_ready_i(mem_req_ready_i), .mem_req_addr_o(mem_req_addr_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
    .rec_valid_o(rec_valid_o), .rec_start_o(rec_start_o),
    .rec_end_o(rec_end_o), .rec_prot_o(rec_prot_o), .done_o(done_o)
  );

  logic [63:0]   mem [0:63];
  logic [AW-1:0] exp_s [0:2047];
  logic [AW-1:0] exp_e [0:2047];
  logic [2:0]    exp_p [0:2047];
  int nexp, nobs, done_cnt, n_chk, n_bad;
  logic [AW-1:0] r_start;
  logic [2:0]    r_cur;
  bit finished;

  function automatic logic [63:0] rd(input logic [23:0] b, input int i);
    return mem[int'(b[15:12]) * 4 + i];
  endfunction
  function automatic logic [2:0] pr(input logic [63:0] e);
    return {e[2], e[1], e[0]};
  endfunction
  function automatic logic [23:0] bs(input logic [63:0] e);
    return {e[23:12], 12'h000};
  endfunction
  function automatic int pg(input int l);
    return (l == 4) ? 1 : 8 - 2 * l;
  endfunction

  task automatic ref_ev(input logic [AW-1:0] a, input logic [2:0] p);
    if (p != r_cur) begin
      if (r_cur != 3'b000) begin
        exp_s[nexp] = r_start; exp_e[nexp] = a; exp_p[nexp] = r_cur;
        nexp++;
      end
      r_start = a;
      r_cur   = p;
    end
  endtask

  // Levels: page 1 = level 4, pages 2-3 = level 3, 4-5 = level 2, 6-7 = level 1, 8-9 = level 0.
  task automatic fill(input int seed, input bit uni);
    for (int k = 0; k < 64; k++) mem[k] = 64'h0;
    for (int l = 4; l >= 1; l--) begin
      for (int p = pg(l); p < pg(l) + ((l == 4) ? 1 : 2); p++) begin
        for (int i = 0; i < 4; i++) begin
          int h;
          logic [63:0] v;
          h = (p * 7 + i * 3 + seed * 5) % 11;
          v = 64'h8000_0000_0000_0F00 | (64'(pg(l - 1) + ((i + seed + p) % 2)) << 12);
          if (uni) v = v | 64'h7;
          else begin
            if (h != 0)          v = v | 64'h1;
            if (h % 3 != 0)      v = v | 64'h4;
            if (h % 4 != 1)      v = v | 64'h2;
            if (h == 4 || h == 7) v = v | 64'h80;
          end
          mem[p * 4 + i] = v;
        end
      end
    end
    for (int p = 8; p < 10; p++) begin
      for (int i = 0; i < 4; i++) begin
        int h;
        logic [63:0] v;
        h = (p * 5 + i * 7 + seed * 3) % 9;
        v = 64'h8000_0000_0000_0F00 | (64'h123 << 12);
        if (uni) v = v | 64'h7;
        else begin
          if (h != 0 && h != 5) v = v | 64'h1;
          if (h % 2 == 1)       v = v | 64'h4;
          if ((h / 2) % 2 == 1) v = v | 64'h2;
          if (h == 3)           v = v | 64'h80;
        end
        mem[p * 4 + i] = v;
      end
    end
  endtask

  task automatic ref_walk(input bit five, input logic [23:0] root);
    logic [63:0] e;
    logic [2:0] p4, p3, p2, p1;
    logic [23:0] b3, b2, b1, b0;
    logic [AW-1:0] a4, a3, a2, a1, a0;
    r_cur = 3'b000; r_start = '0; nexp = 0;
    for (int i4 = 0; i4 < (five ? 4 : 1); i4++) begin
      a4 = AW'(i4) << 20;
      if (five) begin
        e = rd({root[23:12], 12'h000}, i4);
        if (!e[0]) begin ref_ev(a4, 3'b000); continue; end
        p4 = pr(e); b3 = bs(e);
      end else begin
        p4 = 3'b111; b3 = {root[23:12], 12'h000};
      end
      for (int i3 = 0; i3 < 4; i3++) begin
        a3 = a4 | (AW'(i3) << 18);
        e = rd(b3, i3);
        if (!e[0]) begin ref_ev(a3, 3'b000); continue; end
        p3 = p4 & pr(e); b2 = bs(e);
        for (int i2 = 0; i2 < 4; i2++) begin
          a2 = a3 | (AW'(i2) << 16);
          e = rd(b2, i2);
          if (!e[0]) begin ref_ev(a2, 3'b000); continue; end
          if (e[7]) begin ref_ev(a2, p3 & pr(e)); continue; end
          p2 = p3 & pr(e); b1 = bs(e);
          for (int i1 = 0; i1 < 4; i1++) begin
            a1 = a2 | (AW'(i1) << 14);
            e = rd(b1, i1);
            if (!e[0]) begin ref_ev(a1, 3'b000); continue; end
            if (e[7]) begin ref_ev(a1, p2 & pr(e)); continue; end
            p1 = p2 & pr(e); b0 = bs(e);
            for (int i0 = 0; i0 < 4; i0++) begin
              a0 = a1 | (AW'(i0) << 12);
              e = rd(b0, i0);
              ref_ev(a0, e[0] ? (p1 & pr(e)) : 3'b000);
            end
          end
        end
      end
    end
    ref_ev(five ? (AW'(1) << 22) : (AW'(1) << 20), 3'b000);
  endtask

  // Memory responder: one-cycle latency, ready withheld every fourth cycle.
  initial begin
    int cyc, pend_idx;
    bit pend;
    cyc = 0; pend = 0; pend_idx = 0;
    mem_req_ready_i = 1'b0; mem_rsp_valid_i = 1'b0; mem_rsp_data_i = 64'h0;
    forever begin
      @(negedge clk);
      mem_rsp_valid_i = 1'b0;
      mem_req_ready_i = 1'b0;
      if (pend) begin
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = mem[pend_idx];
        pend = 0;
      end else if (rst_n && mem_req_valid_o && (cyc % 4) != 2) begin
        mem_req_ready_i = 1'b1;
        n_chk++;
        if (mem_req_addr_o[11:5] != 7'h0 || mem_req_addr_o[2:0] != 3'h0 ||
            mem_req_addr_o[15:12] == 4'h0 || mem_req_addr_o[15:12] > 4'hA) begin
          n_bad++;
          $display("FAIL R2 R3 read address act %h exp table page 1..10, entry-aligned", mem_req_addr_o);
        end
        pend_idx = int'(mem_req_addr_o[15:12]) * 4 + int'(mem_req_addr_o[4:3]);
        pend = 1;
      end
      cyc++;
    end
  end

  // Record monitor.
  initial begin
    forever begin
      @(negedge clk);
      if (rec_valid_o) begin
        n_chk++;
        if (nobs >= nexp) begin
          n_bad++;
          $display("FAIL R8 R9 extra record act %h..%h p%0d exp none", rec_start_o, rec_end_o, rec_prot_o);
        end else if (rec_start_o != exp_s[nobs] || rec_end_o != exp_e[nobs] || rec_prot_o != exp_p[nobs]) begin
          n_bad++;
          $display("FAIL R5 R6 R7 R8 record %0d act %h..%h p%0d exp %h..%h p%0d", nobs,
                   rec_start_o, rec_end_o, rec_prot_o, exp_s[nobs], exp_e[nobs], exp_p[nobs]);
        end
        nobs++;
      end
      if (done_o) done_cnt++;
    end
  end

  task automatic run(input bit five, input int seed, input bit uni, input logic [23:0] root, input bit poke);
    int d0;
    fill(seed, uni);
    ref_walk(five, root);
    nobs = 0;
    d0 = done_cnt;
    @(negedge clk);
    five_lvl_i = five; root_i = root; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    five_lvl_i = ~five; root_i = 24'h00F000;   // R4: must be ignored after start
    if (poke) begin
      repeat (20) @(negedge clk);
      start_i = 1'b1;                          // R10: start while busy
      @(negedge clk);
      start_i = 1'b0;
    end
    while (done_cnt == d0 && !finished) @(negedge clk);
    repeat (6) @(negedge clk);
    n_chk++;
    if (nobs != nexp || done_cnt != d0 + 1) begin
      n_bad++;
      $display("FAIL R9 R4 R10 mode %0d seed %0d records act %0d exp %0d, done pulses act %0d exp 1",
               five, seed, nobs, nexp, done_cnt - d0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog expired act running exp done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; nexp = 0; nobs = 0; done_cnt = 0; finished = 0;
    rst_n = 1'b0; start_i = 1'b0; five_lvl_i = 1'b0; root_i = '0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (mem_req_valid_o || rec_valid_o || done_o) begin
      n_bad++;
      $display("FAIL R1 in reset act %b%b%b exp 000", mem_req_valid_o, rec_valid_o, done_o);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    n_chk++;
    if (mem_req_valid_o || rec_valid_o || done_o) begin
      n_bad++;
      $display("FAIL R1 idle act %b%b%b exp 000", mem_req_valid_o, rec_valid_o, done_o);
    end
    for (int s = 0; s < 4; s++) run(1'b1, s, 1'b0, 24'h001000, s == 2);
    for (int s = 0; s < 4; s++) run(1'b0, s, 1'b0, 24'h002000, s == 1);
    run(1'b1, 0, 1'b1, 24'h001000, 1'b0);   // R9 single record up to 2^22
    run(1'b0, 0, 1'b1, 24'h002000, 1'b0);   // R9 single record up to 2^20
    run(1'b1, 0, 1'b0, 24'h00A000, 1'b0);   // R7 empty root: no records
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule